// File: doc/BRIEF.md
# Multi-Operand Carry-Save Adder

This block adds a configurable set of equal-width operands into one result. Each operand slot has a static sign control, so a single instance computes expressions such as `p + q - r + s` or `-p - q - r`. It also has a static signedness control, so a narrow operand is widened either by repeating its top bit or by padding with zeros. A compile-time constant can be added to the sum as well. The result wraps modulo 2^OUT_W.

Internally every widened operand that is to be subtracted is bit-inverted. The missing +1 of each two's-complement negation is folded, together with the compile-time constant, into one extra constant operand. The operand set is then compressed by layers of 3:2 full-adder rows, grouped three at a time per layer, until two vectors remain. A single carry-propagate adder then produces the result.

A two-operand instance with no constant skips the tree and uses one adder or subtractor. The block is purely combinational. It has no clock and no handshake, and it is meant to sit inside a pipeline stage that the surrounding logic owns. An expression with nested negations, such as `r - (p - q)`, is flattened into its net per-operand signs before the sign mask is chosen; there `p` is subtracted and `q` is added.

Top module: `csa_multi_adder`

## Requirements
- R1: `result_o` equals the sum over all slots of +ext(op i) or -ext(op i), plus `CONST_ADD`, modulo 2^OUT_W. Operand i sits at `opnd_i[i*IN_W +: IN_W]`, and bit i of `SUB_MASK` set to 1 means that slot is subtracted.
- R2: Bit i of `SGN_MASK` set to 1 widens operand i by sign extension; 0 widens it by zero extension. For example, 0x80 counts as -128 when signed and as 128 when unsigned.
- R3: Overflow wraps silently. With eight unsigned 8-bit operands all equal to 255 and an 8-bit result, the output is 248.
- R4: Mixed signs wrap correctly. For 8-bit `p + q - r + s` with p=1, q=1, r=255 and s=1, the output is 4.
- R5: A two-operand instance without a constant uses one adder or subtractor and no compressor row. With `SUB_MASK` = 2'b10 and 8 bits, it computes op0 - op1, so 5 - 10 gives 251.
- R6: All +1 corrections for subtracted slots are merged with `CONST_ADD` into a single extra tree operand. With every operand zero, the output equals `CONST_ADD`, whatever the sign mask.
- R7: The compressor tree preserves the sum. The two vectors handed to the final adder add up, modulo 2^OUT_W, to the sum of all prepared operands, including the correction operand. Each carry vector is shifted up one bit and its top bit is dropped.
- R8: All-ones inputs are exact under every mix of signedness and sign. A signed all-ones operand counts as -1, and an unsigned one counts as 2^IN_W - 1.
- R9: The output is a combinational function of `opnd_i` and settles within the same time step, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | N_OPS*IN_W | Packed operands, slot i at bits [i*IN_W +: IN_W] |
| result_o | output | OUT_W | Wrapped signed/unsigned sum of all slots plus the constant |

## Verification
The bench builds four instances side by side. The first has six 8-bit slots into a 12-bit result, with three subtracted slots, three signed slots and a constant of 5; it brings sign extension under negation and the merged correction within reach. The second has eight unsigned 8-bit slots into an 8-bit result, a tree four layers deep that exercises wraparound. The third is the four-slot `p + q - r + s` form with one subtracted slot. The fourth is the two-slot subtractor that bypasses the tree. Random operands from a fixed seed are mixed with all-zero, all-ones, single-0x80 and small wrap cases.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Vector count after one 3:2 layer: each full group of three becomes two.
  function automatic int next_cnt(int c);
    return (c > 2) ? (c / 3) * 2 + (c % 3) : c;
  endfunction

  // Vector count present at layer l of a tree that starts with t vectors.
  function automatic int lvl_cnt(int t, int l);
    int c;
    c = t;
    for (int i = 0; i < l; i++) c = next_cnt(c);
    return c;
  endfunction

  // Number of compressor layers needed to get down to two vectors.
  function automatic int num_lvls(int t);
    int c;
    int n;
    c = t;
    n = 0;
    while (c > 2) begin
      c = next_cnt(c);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/csa_operand_prep.sv
module csa_operand_prep #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 12,
  parameter bit SGN   = 1'b0,
  parameter bit NEG   = 1'b0
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic [OUT_W-1:0] term_o
);
  logic [OUT_W-1:0] ext;

  if (OUT_W > IN_W) begin : g_widen
    logic fill;
    assign fill = SGN ? raw_i[IN_W-1] : 1'b0;
    assign ext  = {{(OUT_W-IN_W){fill}}, raw_i};
  end else begin : g_same
    assign ext = raw_i;
  end

  // Negation is completed by the shared correction operand.
  assign term_o = NEG ? ~ext : ext;
endmodule

// File: rtl/csa_fa_row.sv
module csa_fa_row #(
  parameter int W = 12
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] maj;

  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
  assign c_o = maj << 1;
endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import csa_pkg::*;
#(
  parameter int W = 12,
  parameter int T = 7
) (
  input  logic [T*W-1:0] ops_i,
  output logic [W-1:0]   sum_o,
  output logic [W-1:0]   carry_o
);
  localparam int NL = num_lvls(T);

  for (genvar g = 0; g <= NL; g++) begin : lv
    localparam int C = lvl_cnt(T, g);
    wire [C*W-1:0] vec;

    if (g == 0) begin : g_in
      assign vec = ops_i;
    end else begin : g_red
      localparam int P = lvl_cnt(T, g - 1);
      localparam int G = P / 3;
      localparam int R = P % 3;

      for (genvar k = 0; k < G; k++) begin : fa
        csa_fa_row #(.W(W)) u_row (
          .x_i(lv[g-1].vec[(3*k)*W +: W]),
          .y_i(lv[g-1].vec[(3*k+1)*W +: W]),
          .z_i(lv[g-1].vec[(3*k+2)*W +: W]),
          .s_o(vec[(2*k)*W +: W]),
          .c_o(vec[(2*k+1)*W +: W])
        );
      end

      if (R > 0) begin : g_pass
        assign vec[(2*G)*W +: R*W] = lv[g-1].vec[(3*G)*W +: R*W];
      end
    end
  end

  assign sum_o   = lv[NL].vec[0 +: W];
  assign carry_o = lv[NL].vec[W +: W];
endmodule

// File: rtl/csa_multi_adder.sv
module csa_multi_adder
  import csa_pkg::*;
#(
  parameter int               N_OPS     = 6,
  parameter int               IN_W      = 8,
  parameter int               OUT_W     = 12,
  parameter logic [N_OPS-1:0] SUB_MASK  = 6'b100110,
  parameter logic [N_OPS-1:0] SGN_MASK  = 6'b010101,
  parameter logic [OUT_W-1:0] CONST_ADD = 12'd5
) (
  input  logic [N_OPS*IN_W-1:0] opnd_i,
  output logic [OUT_W-1:0]      result_o
);
  localparam int               NSUB   = $countones(SUB_MASK);
  localparam bit               BYPASS = (N_OPS == 2) && (CONST_ADD == '0) &&
                                        (SUB_MASK != 2'b11);
  localparam bit               HAS_K  = !BYPASS && ((NSUB != 0) || (CONST_ADD != '0));
  localparam int               T      = N_OPS + (HAS_K ? 1 : 0);
  localparam logic [OUT_W-1:0] CORR   = CONST_ADD + OUT_W'(NSUB);

  logic [T*OUT_W-1:0] term_flat;
  logic [OUT_W-1:0]   red_s;
  logic [OUT_W-1:0]   red_c;

  for (genvar i = 0; i < N_OPS; i++) begin : g_prep
    csa_operand_prep #(
      .IN_W (IN_W),
      .OUT_W(OUT_W),
      .SGN  (SGN_MASK[i]),
      .NEG  (SUB_MASK[i] && !BYPASS)
    ) u_prep (
      .raw_i (opnd_i[i*IN_W +: IN_W]),
      .term_o(term_flat[i*OUT_W +: OUT_W])
    );
  end

  if (HAS_K) begin : g_corr
    assign term_flat[N_OPS*OUT_W +: OUT_W] = CORR;
  end

  if (BYPASS) begin : g_pair
    localparam int PI = SUB_MASK[0] ? 1 : 0;
    assign red_s = term_flat[PI*OUT_W +: OUT_W];
    assign red_c = term_flat[(1-PI)*OUT_W +: OUT_W];
    assign result_o = (SUB_MASK != '0) ? red_s - red_c : red_s + red_c;
  end else begin : g_tree
    csa_tree #(.W(OUT_W), .T(T)) u_tree (
      .ops_i  (term_flat),
      .sum_o  (red_s),
      .carry_o(red_c)
    );
    assign result_o = red_s + red_c;
  end
endmodule

// File: rtl/csa_multi_adder_chk.sv
module csa_multi_adder_chk #(
  parameter int               N_OPS     = 6,
  parameter int               IN_W      = 8,
  parameter int               OUT_W     = 12,
  parameter logic [N_OPS-1:0] SUB_MASK  = 6'b100110,
  parameter logic [N_OPS-1:0] SGN_MASK  = 6'b010101,
  parameter logic [OUT_W-1:0] CONST_ADD = 12'd5
) (
  input logic [N_OPS*IN_W-1:0] opnd_i,
  input logic [OUT_W-1:0]      result_o,
  input logic [((N_OPS == 2) && (CONST_ADD == '0) && (SUB_MASK != 2'b11)) ||
               ((SUB_MASK == '0) && (CONST_ADD == '0)) ?
               N_OPS*OUT_W-1 : (N_OPS+1)*OUT_W-1 : 0] term_flat,
  input logic [OUT_W-1:0]      red_s,
  input logic [OUT_W-1:0]      red_c
);
  localparam bit BYPASS = (N_OPS == 2) && (CONST_ADD == '0) && (SUB_MASK != 2'b11);
  localparam int T      = $bits(term_flat) / OUT_W;

  always_comb begin : chk
    logic [OUT_W-1:0] ref_acc;
    logic [OUT_W-1:0] term_acc;
    logic [OUT_W-1:0] ext;
    logic             neg;
    ref_acc  = CONST_ADD;
    term_acc = '0;
    for (int i = 0; i < N_OPS; i++) begin
      neg = SUB_MASK[i] && !BYPASS;
      ext = SGN_MASK[i] ? OUT_W'($signed(opnd_i[i*IN_W +: IN_W]))
                        : OUT_W'(opnd_i[i*IN_W +: IN_W]);
      ref_acc = SUB_MASK[i] ? ref_acc - ext : ref_acc + ext;
      a_r2_widen: assert (term_flat[i*OUT_W +: OUT_W] == (neg ? ~ext : ext))
        else $error("operand %0d prepared wrongly", i);
    end
    for (int j = 0; j < T; j++) term_acc = term_acc + term_flat[j*OUT_W +: OUT_W];

    a_r1_signed_sum: assert (result_o == ref_acc)
      else $error("result %0h differs from signed sum %0h", result_o, ref_acc);
    if (!BYPASS) begin
      a_r7_tree_keeps_sum: assert (OUT_W'(red_s + red_c) == term_acc)
        else $error("tree output pair does not preserve the sum");
    end
    if (opnd_i == '0) begin
      a_r6_zero_gives_const: assert (result_o == CONST_ADD)
        else $error("zero operands did not give the constant");
    end
  end
endmodule

bind csa_multi_adder csa_multi_adder_chk #(
  .N_OPS    (N_OPS),
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .SUB_MASK (SUB_MASK),
  .SGN_MASK (SGN_MASK),
  .CONST_ADD(CONST_ADD)
) u_chk (
  .opnd_i   (opnd_i),
  .result_o (result_o),
  .term_flat(term_flat),
  .red_s    (red_s),
  .red_c    (red_c)
);

// File: tb/tb_csa_multi_adder.sv
module tb_csa_multi_adder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [47:0] a_in = '0;  logic [11:0] a_out;
  logic [63:0] b_in = '0;  logic [7:0]  b_out;
  logic [31:0] c_in = '0;  logic [7:0]  c_out;
  logic [15:0] d_in = '0;  logic [7:0]  d_out;

  csa_multi_adder #(.N_OPS(6), .IN_W(8), .OUT_W(12), .SUB_MASK(6'b100110),
                    .SGN_MASK(6'b010101), .CONST_ADD(12'd5))
    dut (.opnd_i(a_in), .result_o(a_out));
  csa_multi_adder #(.N_OPS(8), .IN_W(8), .OUT_W(8), .SUB_MASK(8'h00),
                    .SGN_MASK(8'h00), .CONST_ADD(8'd0))
    dut_wrap (.opnd_i(b_in), .result_o(b_out));
  csa_multi_adder #(.N_OPS(4), .IN_W(8), .OUT_W(8), .SUB_MASK(4'b0100),
                    .SGN_MASK(4'b0000), .CONST_ADD(8'd0))
    dut_mix (.opnd_i(c_in), .result_o(c_out));
  csa_multi_adder #(.N_OPS(2), .IN_W(8), .OUT_W(8), .SUB_MASK(2'b10),
                    .SGN_MASK(2'b00), .CONST_ADD(8'd0))
    dut_pair (.opnd_i(d_in), .result_o(d_out));

  function automatic longint ref_sum(int n, int outw, int sub, int sgn, longint k,
                                     logic [63:0] flat);
    longint acc = k;
    for (int i = 0; i < n; i++) begin
      longint v = longint'(flat[i*8 +: 8]);
      if (((sgn >> i) & 1) == 1 && v >= 128) v = v - 256;
      if (((sub >> i) & 1) == 1) acc = acc - v;
      else acc = acc + v;
    end
    return acc & ((longint'(1) << outw) - 1);
  endfunction

  task automatic check(string req, string who, longint got, longint exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, who, got, exp);
    end
  endtask

  // Drive all four instances, let the combinational paths settle, compare (R1, R7, R9).
  task automatic apply(logic [47:0] a, logic [63:0] b, logic [31:0] c, logic [15:0] d,
                       string req);
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; d_in = d;
    #1;
    check(req, "six-slot", longint'(a_out), ref_sum(6, 12, 6'b100110, 6'b010101, 5, 64'(a)));
    check(req, "eight-slot", longint'(b_out), ref_sum(8, 8, 0, 0, 0, b));
    check(req, "four-slot", longint'(c_out), ref_sum(4, 8, 4'b0100, 0, 0, 64'(c)));
    check(req, "two-slot", longint'(d_out), ref_sum(2, 8, 2'b10, 0, 0, 64'(d)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: all operands zero, output is just the constant (R6).
    check("R6", "six-slot zero", longint'(a_out), 5);
    check("R6", "eight-slot zero", longint'(b_out), 0);
    check("R6", "two-slot zero", longint'(d_out), 0);

    apply('0, '0, '0, '0, "R6");
    apply('1, '1, '1, '1, "R8");
    check("R3", "eight 255s", longint'(b_out), 248);
    check("R8", "six-slot all ones", longint'(a_out), 3845);
    apply(48'h0, 64'h0, {8'd1, 8'd255, 8'd1, 8'd1}, {8'd10, 8'd5}, "R4");
    check("R4", "1+1-255+1", longint'(c_out), 4);
    check("R5", "5-10", longint'(d_out), 251);
    apply(48'h00_00_00_00_00_80, 64'h80, 32'h0, {8'd5, 8'd10}, "R2");
    check("R2", "signed 0x80", longint'(a_out), 3973);
    check("R5", "10-5", longint'(d_out), 5);
    apply(48'h00_00_80_00_00_00, 64'h0, 32'h0, 16'h0, "R2");
    check("R2", "unsigned 0x80", longint'(a_out), 133);
    apply(48'h80_80_80_80_80_80, {8{8'h80}}, {4{8'h80}}, {2{8'h80}}, "R8");

    void'($urandom(32'h5eed_c5a1));
    for (int it = 0; it < 300; it++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, $urandom(),
            16'($urandom()), "R1 R7 R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule